// File: doc/BRIEF.md
# Folded Symmetric FIR Filter with Shared Multipliers

This block filters a stream of signed samples with a linear-phase FIR of odd order. Because the impulse response is symmetric, the two samples that share a coefficient are added first. The result is a set of tap sums, and each tap sum needs only one multiply. A small bank of `NUM_MUL` multipliers is reused over `NUM_CYC` serial cycles per input sample. In cycle c, multiplier m works on tap index `NUM_MUL*c + m`.

A sample is loaded with a one-clock strobe. The coefficients come from an internal read-only table that returns one coefficient per multiplier in every serial cycle. The products pass through a six-register pipeline: tap select, tap sum, multiply, adder tree, accumulate and output. The output keeps full precision and is shifted left by `OUT_SHIFT` bits, so that filters with different fractional scaling give outputs that can be summed directly. A strobe that arrives before the current sample has finished its serial cycles is reported on an overrun output.

Top module: `sfir_top`

## Requirements
- R1: Each accepted sample x(n) produces y(n) = sum over k < T of f_k·(x(n−k) + x(n−L+k)). Here L = `ORDER` (odd) and T = (L+1)/2. The delay line advances by exactly one position per strobe.
- R2: The coefficient table holds f_k = ((7919·k) mod 2^COEF_W) − 2^(COEF_W−1) for k < T, and 0 for T ≤ k < NUM_MUL·NUM_CYC. An impulse therefore reproduces f_0, f_1, … and then the mirrored tail.
- R3: `valid_o` is high for exactly one clock. That clock comes NUM_CYC+5 rising edges after the edge that sampled the strobe.
- R4: `data_o` equals y(n)·2^OUT_SHIFT, sign-extended to the full output width, with no rounding or truncation.
- R5: A strobe sampled while the previous sample has serial cycles still to issue (fewer than NUM_CYC edges after its strobe) raises `overrun_o` for one clock, visible right after that edge. Strobes spaced exactly NUM_CYC clocks apart never raise it.
- R6: After an overrun, the interrupted sample produces no output. The new sample is still shifted in, its accumulation starts from zero, and its result appears with the R3 latency.
- R7: After reset, `valid_o`, `overrun_o` and `data_o` are 0 and the delay line holds zeros.
- R8: Full-scale inputs (all samples at +2^(DATA_W−1)−1, or all at −2^(DATA_W−1)) give exact results with no wrap in the tap sums or in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | New-sample strobe |
| sample_i | input | DATA_W | Signed input sample |
| data_o | output | OUT_W | Signed filter result, full precision, shifted left |
| valid_o | output | 1 | One-clock result strobe |
| overrun_o | output | 1 | Strobe arrived while the serial cycles were still running |

## Verification
A delay line that loses or repeats a position breaks every later result. The fault appears at the first output after the fault and persists until L+1 further samples have flushed it out. A serial counter that ends early, or a first-cycle clear that does not happen, corrupts the very next `valid_o` value or moves it off its NUM_CYC+5 slot. A wrong table word shows up in the impulse response at the exact output that matches its tap index. Overrun handling is checked on the clock after the offending strobe. The bench also confirms that no stale result from the interrupted sample appears.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } sfir_tag_t;
endpackage

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
#(
  parameter int NUM_CYC = 24,
  localparam int CNT_W = $clog2(NUM_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_vld_i,
  output logic [CNT_W-1:0] cyc_o,
  output sfir_tag_t        tag_o,
  output logic             overrun_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= sample_vld_i & busy_q & (cnt_q != LAST_CNT);
      if (sample_vld_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST_CNT) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cyc_o     = cnt_q;
  assign tag_o.vld   = busy_q;
  assign tag_o.first = busy_q && (cnt_q == '0);
  assign tag_o.last  = busy_q && (cnt_q == LAST_CNT);
  assign overrun_o   = ovr_q;

  AST_STROBE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |=> tag_o.first); // R1
  AST_LAST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_o.last && !sample_vld_i) |=> !tag_o.vld); // R5
  AST_OVR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_vld_i |=> !overrun_o); // R5
endmodule

// File: rtl/sfir_coef_rom.sv
module sfir_coef_rom #(
  parameter int NUM_MUL  = 8,
  parameter int NUM_CYC  = 24,
  parameter int COEF_W   = 18,
  parameter int NUM_TAPS = 192,
  localparam int CNT_W  = $clog2(NUM_CYC),
  localparam int WORD_W = NUM_MUL * COEF_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic [CNT_W-1:0]                addr_i,
  output logic [NUM_MUL-1:0][COEF_W-1:0]  word_o
);
  function automatic logic [COEF_W-1:0] coef_at(int k);
    int v;
    if (k >= NUM_TAPS) return '0;
    v = (k * 7919) % (1 << COEF_W);
    return COEF_W'(v) ^ (COEF_W'(1) << (COEF_W - 1));
  endfunction

  function automatic logic [WORD_W-1:0] rom_word(int c);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int m = 0; m < NUM_MUL; m++) w[m*COEF_W +: COEF_W] = coef_at(c * NUM_MUL + m);
    return w;
  endfunction

  logic [WORD_W-1:0] rom_mem [NUM_CYC];

  for (genvar c = 0; c < NUM_CYC; c++) begin : g_rom
    assign rom_mem[c] = rom_word(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (en_i) word_o <= rom_mem[addr_i];
  end
endmodule

// File: rtl/sfir_taps.sv
module sfir_taps #(
  parameter int DATA_W  = 17,
  parameter int MUL_W   = 18,
  parameter int NUM_MUL = 8,
  parameter int NUM_CYC = 24,
  parameter int ORDER   = 383,
  localparam int CNT_W    = $clog2(NUM_CYC),
  localparam int DEPTH    = ORDER + 1,
  localparam int NUM_TAPS = (ORDER + 1) / 2,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           shift_i,
  input  logic [DATA_W-1:0]              sample_i,
  input  logic                           rd_i,
  input  logic [CNT_W-1:0]               cyc_i,
  output logic [NUM_MUL-1:0][MUL_W-1:0]  tsum_o
);
  logic signed [DATA_W-1:0] dl_q [DEPTH];
  logic signed [DATA_W-1:0] a_d [NUM_MUL];
  logic signed [DATA_W-1:0] b_d [NUM_MUL];
  logic signed [DATA_W-1:0] a_q [NUM_MUL];
  logic signed [DATA_W-1:0] b_q [NUM_MUL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) dl_q[i] <= '0;
    end else if (shift_i) begin
      dl_q[0] <= $signed(sample_i);
      for (int i = 1; i < DEPTH; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  // mirrored pair for tap k = cyc*M + m; taps beyond T read as zero
  always_comb begin
    for (int m = 0; m < NUM_MUL; m++) begin
      int k;
      k = int'(cyc_i) * NUM_MUL + m;
      if (k < NUM_TAPS) begin
        a_d[m] = dl_q[IDX_W'(k)];
        b_d[m] = dl_q[IDX_W'(ORDER - k)];
      end else begin
        a_d[m] = '0;
        b_d[m] = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_MUL; m++) begin
        a_q[m] <= '0;
        b_q[m] <= '0;
      end
      tsum_o <= '0;
    end else begin
      if (rd_i) begin
        for (int m = 0; m < NUM_MUL; m++) begin
          a_q[m] <= a_d[m];
          b_q[m] <= b_d[m];
        end
      end
      for (int m = 0; m < NUM_MUL; m++) tsum_o[m] <= MUL_W'(a_q[m]) + MUL_W'(b_q[m]);
    end
  end

  AST_DL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (dl_q[1] == $past(dl_q[0]))); // R1
  AST_DL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(dl_q[0])); // R1
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac
  import sfir_pkg::*;
#(
  parameter int MUL_W     = 18,
  parameter int COEF_W    = 18,
  parameter int NUM_MUL   = 8,
  parameter int NUM_CYC   = 24,
  parameter int OUT_SHIFT = 0,
  localparam int PROD_W = MUL_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(NUM_MUL * NUM_CYC),
  localparam int OUT_W  = ACC_W + OUT_SHIFT
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  sfir_tag_t                       tag_i,
  input  logic [NUM_MUL-1:0][COEF_W-1:0]  coef_i,
  input  logic [NUM_MUL-1:0][MUL_W-1:0]   tsum_i,
  output logic [OUT_W-1:0]                data_o,
  output logic                            valid_o
);
  sfir_tag_t t1_q, t2_q, t3_q, t4_q, t5_q;
  logic [NUM_MUL-1:0][COEF_W-1:0] coef2_q;
  logic signed [PROD_W-1:0] prod_q [NUM_MUL];
  logic signed [ACC_W-1:0]  tree_d, tree_q, acc_q;

  always_comb begin
    tree_d = '0;
    for (int m = 0; m < NUM_MUL; m++) tree_d = tree_d + ACC_W'(prod_q[m]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q <= '0; t2_q <= '0; t3_q <= '0; t4_q <= '0; t5_q <= '0;
      coef2_q <= '0;
      for (int m = 0; m < NUM_MUL; m++) prod_q[m] <= '0;
      tree_q  <= '0;
      acc_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      t1_q <= tag_i;
      t2_q <= t1_q;
      t3_q <= t2_q;
      t4_q <= t3_q;
      t5_q <= t4_q;
      coef2_q <= coef_i;
      for (int m = 0; m < NUM_MUL; m++)
        prod_q[m] <= $signed(tsum_i[m]) * $signed(coef2_q[m]);
      tree_q <= tree_d;
      if (t4_q.vld) acc_q <= t4_q.first ? tree_q : acc_q + tree_q;
      valid_o <= t5_q.vld & t5_q.last;
      if (t5_q.vld && t5_q.last) data_o <= OUT_W'(acc_q) <<< OUT_SHIFT;
    end
  end

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t4_q.vld && t4_q.first) |=> (acc_q == $past(tree_q))); // R6
  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t4_q.vld |=> $stable(acc_q)); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R3
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o) || $past(t5_q.last)); // R4
endmodule

// File: rtl/sfir_top.sv
module sfir_top
  import sfir_pkg::*;
#(
  parameter int DATA_W    = 17,
  parameter int MUL_W     = 18,
  parameter int COEF_W    = 18,
  parameter int NUM_MUL   = 8,
  parameter int NUM_CYC   = 24,
  parameter int ORDER     = 383,
  parameter int OUT_SHIFT = 0,
  localparam int OUT_W = MUL_W + COEF_W + $clog2(NUM_MUL * NUM_CYC) + OUT_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_vld_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              valid_o,
  output logic              overrun_o
);
  localparam int CNT_W    = $clog2(NUM_CYC);
  localparam int NUM_TAPS = (ORDER + 1) / 2;

  logic [CNT_W-1:0]               cyc;
  sfir_tag_t                      tag;
  logic [NUM_MUL-1:0][COEF_W-1:0] coef;
  logic [NUM_MUL-1:0][MUL_W-1:0]  tsum;

  sfir_ctrl #(.NUM_CYC(NUM_CYC)) u_ctrl (
    .clk_i, .rst_ni, .sample_vld_i,
    .cyc_o(cyc), .tag_o(tag), .overrun_o
  );

  sfir_coef_rom #(.NUM_MUL(NUM_MUL), .NUM_CYC(NUM_CYC), .COEF_W(COEF_W),
                  .NUM_TAPS(NUM_TAPS)) u_rom (
    .clk_i, .rst_ni, .en_i(tag.vld), .addr_i(cyc), .word_o(coef)
  );

  sfir_taps #(.DATA_W(DATA_W), .MUL_W(MUL_W), .NUM_MUL(NUM_MUL),
              .NUM_CYC(NUM_CYC), .ORDER(ORDER)) u_taps (
    .clk_i, .rst_ni, .shift_i(sample_vld_i), .sample_i,
    .rd_i(tag.vld), .cyc_i(cyc), .tsum_o(tsum)
  );

  sfir_mac #(.MUL_W(MUL_W), .COEF_W(COEF_W), .NUM_MUL(NUM_MUL),
             .NUM_CYC(NUM_CYC), .OUT_SHIFT(OUT_SHIFT)) u_mac (
    .clk_i, .rst_ni, .tag_i(tag), .coef_i(coef), .tsum_i(tsum),
    .data_o, .valid_o
  );

  AST_NO_STROBE_NO_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o) |-> $past(sample_vld_i)); // R5
endmodule

// File: tb/sfir_top_tb_top.sv
module sfir_top_tb_top;
  localparam int DATA_W = 17, MUL_W = 18, COEF_W = 18, NUM_MUL = 8, NUM_CYC = 24;
  localparam int ORDER = 383, OUT_SHIFT = 3;
  localparam int NUM_TAPS = (ORDER + 1) / 2;
  localparam int OUT_W = MUL_W + COEF_W + $clog2(NUM_MUL * NUM_CYC) + OUT_SHIFT;
  localparam int LAT = NUM_CYC + 5;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic [DATA_W-1:0] smp = '0;
  logic [OUT_W-1:0] data;
  logic valid, ovr;

  sfir_top #(.DATA_W(DATA_W), .MUL_W(MUL_W), .COEF_W(COEF_W), .NUM_MUL(NUM_MUL),
             .NUM_CYC(NUM_CYC), .ORDER(ORDER), .OUT_SHIFT(OUT_SHIFT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .sample_i(smp),
    .data_o(data), .valid_o(valid), .overrun_o(ovr)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, last_e = -1000;
  bit run_chk = 0;
  string cur_req = "R1";
  int hist[$];
  int due_q[$];
  longint val_q[$];
  int ovr_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef(int k);
    if (k >= NUM_TAPS) return 0;
    return longint'((k * 7919) % (1 << COEF_W)) - longint'(1 << (COEF_W - 1));
  endfunction

  function automatic longint model_y();
    longint y = 0;
    for (int k = 0; k < NUM_TAPS; k++)
      y += coef(k) * longint'(hist[k] + hist[ORDER - k]);
    return y * (longint'(1) << OUT_SHIFT);
  endfunction

  task automatic send(int x, int gap);
    int e;
    @(negedge clk);
    vld = 1'b1;
    smp = DATA_W'(x);
    e = cyc + 1;
    if (e - last_e < NUM_CYC) begin
      ovr_q.push_back(e);                     // R5
      if (due_q.size() > 0) begin             // R6: interrupted sample drops
        void'(due_q.pop_back());
        void'(val_q.pop_back());
      end
    end
    last_e = e;
    hist.push_front(x);
    void'(hist.pop_back());
    due_q.push_back(e + LAT);
    val_q.push_back(model_y());
    @(negedge clk);
    vld = 1'b0;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (run_chk) begin
      bit exp_v, exp_o;
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      exp_o = (ovr_q.size() > 0) && (ovr_q[0] == cyc);
      checks++;
      if (valid !== exp_v) begin
        failures++;
        $display("FAIL R3 valid at cycle %0d: got %b exp %b", cyc, valid, exp_v);
      end
      if (exp_v) begin
        checks++;
        if (longint'($signed(data)) !== val_q[0]) begin
          failures++;
          $display("FAIL R1/R4/%s data: got %0d exp %0d", cur_req, longint'($signed(data)), val_q[0]);
        end
        void'(due_q.pop_front());
        void'(val_q.pop_front());
      end
      checks++;
      if (ovr !== exp_o) begin
        failures++;
        $display("FAIL R5 overrun at cycle %0d: got %b exp %b", cyc, ovr, exp_o);
      end
      if (exp_o) void'(ovr_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: got running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lfsr = 32'h1234_5678;
    for (int i = 0; i <= ORDER; i++) hist.push_back(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid !== 1'b0 || ovr !== 1'b0 || data !== '0) begin
      failures++;
      $display("FAIL R7 reset outputs: got v=%b o=%b d=%0d exp 0 0 0", valid, ovr, data);
    end
    run_chk = 1;

    // R2: impulse through the full window at the minimum strobe spacing
    cur_req = "R2";
    send(1, NUM_CYC);
    for (int i = 0; i < ORDER + 4; i++) send(0, NUM_CYC);

    // R1: pseudo-random samples, looser spacing
    cur_req = "R1";
    for (int i = 0; i < 100; i++) begin
      lfsr = lfsr * 1103515245 + 12345;
      send(((lfsr >>> 8) % 131072) - 65536 + ((lfsr >>> 8) % 131072 < 0 ? 131072 : 0), NUM_CYC + 3);
    end

    // R8: full-scale positive then negative
    cur_req = "R8";
    for (int i = 0; i <= ORDER; i++) send(65535, NUM_CYC);
    for (int i = 0; i <= ORDER; i++) send(-65536, NUM_CYC);

    // R6: overrun restarts the serial cycles
    cur_req = "R6";
    send(1000, 5);
    send(-2000, NUM_CYC);
    send(300, 1);
    send(-7, NUM_CYC + 2);
    for (int i = 0; i < 4; i++) send(i * 111 - 50, NUM_CYC);

    repeat (LAT + 10) @(negedge clk);
    checks++;
    if (due_q.size() != 0 || ovr_q.size() != 0) begin
      failures++;
      $display("FAIL R3 pending results: got %0d exp 0", due_q.size() + ovr_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule